// File: doc/BRIEF.md
# PTP Frame Timestamp Unit

The unit sits beside one direction of a gigabit Ethernet MAC and watches its byte-wide data stream. A transmit path and a receive path each get their own instance. When the start-of-frame delimiter passes, the unit takes a copy of the local time-of-day (seconds and nanoseconds). It then walks the frame headers to decide whether the frame carries a Precision Time Protocol message. The copy is kept only for frames that qualify. For those frames, the unit builds a 128-bit record holding the captured time, the message type nibble, a checksum field and the sequence number, and writes it into a small dual-clock queue.

Header walking is done on 32-bit words. Each word is collected over four byte-clock cycles, so every parsing decision has four cycles in which to settle. The words are aligned two bytes behind the frame start, which puts every field that follows the first EtherType on a word boundary. This holds for Layer-2 PTP, UDP over IPv4 (header length taken from its length nibble) and UDP over IPv6, with up to two VLAN tags and any number of MPLS labels ahead of the IP header.

The host side runs on its own clock. It drains records with a request/acknowledge handshake and can poll the empty flag. On the byte side, a full flag and a sticky overflow flag show when records have been dropped.

Top module: `ptp_stamp_unit`

## Requirements
- R1: A record is packed, most significant bit first, as: 16 zero bits, 48-bit seconds, 32-bit nanoseconds, 4-bit message type, 12-bit checksum field, 16-bit sequence number. The message type is the low nibble of PTP byte 0. The sequence number is PTP bytes 30-31, first byte most significant.
- R2: A frame whose EtherType is 0x88F7 is a Layer-2 PTP frame, and its record has a checksum field of zero.
- R3: For EtherType 0x0800 with version nibble 4 and protocol 17, the UDP header is found 4×IHL bytes after the IP header start (IHL at least 5). The checksum field is the low 12 bits of the UDP checksum.
- R4: For EtherType 0x86DD with version nibble 6 and next-header 17, the UDP header is found 40 bytes after the IP header start. The checksum field is the low 12 bits of the UDP checksum.
- R5: A UDP frame is kept only when its destination port is 319 or 320. Any other port gives no record.
- R6: One or two 0x8100 VLAN tags ahead of the EtherType are skipped. A frame with a third tag gives no record.
- R7: After EtherType 0x8847, 4-byte MPLS labels are skipped until one has its bottom-of-stack bit set (bit 0 of the label's third byte). The version nibble of the following byte then selects IPv4 or IPv6.
- R8: The time is captured in the cycle that carries the 0xD5 delimiter, the first 0xD5 after `gmii_dv` rises. No record is written for a frame that is not PTP, or for one that ends before its sequence number.
- R9: While `rd_req` is high and the queue is not empty, the unit pops the oldest record onto `rd_data` and raises `rd_ack` for exactly one host cycle. With the queue empty, no acknowledge is given.
- R10: The queue holds 16 records. `fifo_full` is high while 16 are stored. A record arriving while full is dropped, and `overflow` is set and stays set until reset.
- R11: After reset, `fifo_empty` is 1 and `fifo_full`, `overflow`, `rd_ack` and `rd_data` are 0.
- R12: A frame whose first EtherType is none of 0x88F7, 0x8100, 0x8847, 0x0800, 0x86DD gives no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Byte clock of the watched stream |
| rx_rst_n | input | 1 | Active-low reset, byte clock domain |
| gmii_dv | input | 1 | Byte valid, high for the whole frame including preamble |
| gmii_d | input | 8 | Stream byte |
| rtc_sec | input | 48 | Time-of-day seconds, byte clock domain |
| rtc_ns | input | 32 | Time-of-day nanoseconds, byte clock domain |
| fifo_full | output | 1 | Queue holds 16 records (byte clock domain) |
| overflow | output | 1 | Sticky: a record was dropped on a full queue |
| host_clk | input | 1 | Host read clock |
| host_rst_n | input | 1 | Active-low reset, host clock domain |
| rd_req | input | 1 | Host read request |
| rd_ack | output | 1 | One-cycle acknowledge, `rd_data` valid |
| rd_data | output | 128 | Popped record |
| fifo_empty | output | 1 | Queue empty (host clock domain) |

## Verification
The assertions assume that `gmii_dv` goes low between frames, so the delimiter latch can re-arm. They also assume that the host drops `rd_req` once `rd_ack` is seen, giving one pop per request, and that both resets are applied together. The bench drives every byte on the falling edge of its clock with a gap of idle cycles after each frame. It raises `rd_req` only through a task that lowers it on the acknowledge, and it never reads until the write pointer has had several host cycles to cross the clock boundary.

// File: rtl/ptp_stamp_unit.sv
module ptp_stamp_unit #(
  parameter int AW = 4
) (
  input  logic         rx_clk,
  input  logic         rx_rst_n,
  input  logic         gmii_dv,
  input  logic [7:0]   gmii_d,
  input  logic [47:0]  rtc_sec,
  input  logic [31:0]  rtc_ns,
  output logic         fifo_full,
  output logic         overflow,
  input  logic         host_clk,
  input  logic         host_rst_n,
  input  logic         rd_req,
  output logic         rd_ack,
  output logic [127:0] rd_data,
  output logic         fifo_empty
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [3:0] {
    S_IDLE, S_ET, S_MPLS, S_IP, S_IP4P, S_IP6P, S_UDP, S_UCS, S_PTP, S_SEQ
  } st_t;

  st_t         st;
  logic        seen_sfd, wstb;
  logic [10:0] bcnt;
  logic [23:0] sh;
  logic [31:0] word;
  logic [8:0]  widx, ptr;
  logic [3:0]  ihl, msg;
  logic [1:0]  vcnt;
  logic [11:0] csum;
  logic [47:0] cap_sec;
  logic [31:0] cap_ns;

  wire sfd_hit = gmii_dv && !seen_sfd && gmii_d == 8'hD5;
  wire at      = wstb && widx == ptr;
  wire rec_push = at && st == S_SEQ;
  wire [127:0] rec = {16'h0000, cap_sec, cap_ns, msg, csum, word[15:0]};

  // word assembly: two phantom bytes make every post-EtherType field word aligned
  always_ff @(posedge rx_clk or negedge rx_rst_n) begin
    if (!rx_rst_n) begin
      seen_sfd <= 1'b0;
      wstb     <= 1'b0;
      bcnt     <= '0;
      sh       <= '0;
      word     <= '0;
      widx     <= '0;
      cap_sec  <= '0;
      cap_ns   <= '0;
    end else begin
      wstb <= 1'b0;
      if (!gmii_dv) seen_sfd <= 1'b0;
      if (sfd_hit) begin
        seen_sfd <= 1'b1;
        bcnt     <= 11'd2;
        sh       <= '0;
        cap_sec  <= rtc_sec;
        cap_ns   <= rtc_ns;
      end else if (gmii_dv && seen_sfd) begin
        sh   <= {sh[15:0], gmii_d};
        bcnt <= bcnt + 11'd1;
        if (bcnt[1:0] == 2'd3) begin
          word <= {sh, gmii_d};
          wstb <= 1'b1;
          widx <= bcnt[10:2];
        end
      end
    end
  end

  always_ff @(posedge rx_clk or negedge rx_rst_n) begin
    if (!rx_rst_n) begin
      st   <= S_IDLE;
      ptr  <= '0;
      ihl  <= '0;
      msg  <= '0;
      vcnt <= '0;
      csum <= '0;
    end else if (sfd_hit) begin
      st   <= S_ET;
      ptr  <= 9'd3;
      vcnt <= '0;
    end else if (!gmii_dv) begin
      st <= S_IDLE;
    end else if (at) begin
      case (st)
        S_ET: begin
          ptr <= ptr + 9'd1;
          case (word[15:0])
            16'h8100: if (vcnt == 2'd2) st <= S_IDLE; else vcnt <= vcnt + 2'd1;
            16'h88F7: begin st <= S_PTP; csum <= '0; end
            16'h8847: st <= S_MPLS;
            16'h0800, 16'h86DD: st <= S_IP;
            default:  st <= S_IDLE;
          endcase
        end
        S_MPLS: begin
          ptr <= ptr + 9'd1;
          if (word[8]) st <= S_IP;
        end
        S_IP: begin
          if (word[31:28] == 4'd4 && word[27:24] >= 4'd5) begin
            ihl <= word[27:24];
            ptr <= ptr + 9'd2;
            st  <= S_IP4P;
          end else if (word[31:28] == 4'd6) begin
            ptr <= ptr + 9'd1;
            st  <= S_IP6P;
          end else st <= S_IDLE;
        end
        S_IP4P: begin
          ptr <= ptr - 9'd2 + {5'd0, ihl};
          st  <= (word[23:16] == 8'd17) ? S_UDP : S_IDLE;
        end
        S_IP6P: begin
          ptr <= ptr + 9'd9;
          st  <= (word[15:8] == 8'd17) ? S_UDP : S_IDLE;
        end
        S_UDP: begin
          ptr <= ptr + 9'd1;
          st  <= (word[15:0] == 16'd319 || word[15:0] == 16'd320) ? S_UCS : S_IDLE;
        end
        S_UCS: begin
          csum <= word[11:0];
          ptr  <= ptr + 9'd1;
          st   <= S_PTP;
        end
        S_PTP: begin
          msg <= word[27:24];
          ptr <= ptr + 9'd7;
          st  <= S_SEQ;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // dual-clock queue with gray pointers
  logic [127:0] mem [DEPTH];
  logic [AW:0]  wbin, wgray, rq1, rq2, rbin, rgray, wq1, wq2;
  wire  [AW:0]  wnext = wbin + 1'b1;
  wire  [AW:0]  rnext = rbin + 1'b1;

  assign fifo_full  = wgray == {~rq2[AW:AW-1], rq2[AW-2:0]};
  assign fifo_empty = rgray == wq2;

  always_ff @(posedge rx_clk) begin
    if (rec_push && !fifo_full) mem[wbin[AW-1:0]] <= rec;
  end

  always_ff @(posedge rx_clk or negedge rx_rst_n) begin
    if (!rx_rst_n) begin
      wbin     <= '0;
      wgray    <= '0;
      rq1      <= '0;
      rq2      <= '0;
      overflow <= 1'b0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (rec_push && !fifo_full) begin
        wbin  <= wnext;
        wgray <= wnext ^ (wnext >> 1);
      end
      if (rec_push && fifo_full) overflow <= 1'b1;
    end
  end

  always_ff @(posedge host_clk or negedge host_rst_n) begin
    if (!host_rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      wq1     <= '0;
      wq2     <= '0;
      rd_ack  <= 1'b0;
      rd_data <= '0;
    end else begin
      wq1    <= wgray;
      wq2    <= wq1;
      rd_ack <= 1'b0;
      if (rd_req && !rd_ack && !fifo_empty) begin
        rd_ack  <= 1'b1;
        rd_data <= mem[rbin[AW-1:0]];
        rbin    <= rnext;
        rgray   <= rnext ^ (rnext >> 1);
      end
    end
  end

  AST_FULL_DROP: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    (rec_push && fifo_full) |=> ($stable(wbin) && overflow)); // R10
  AST_OVF_STICKY: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    overflow |=> overflow); // R10
  AST_TIME_HELD: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    (st != S_IDLE && !sfd_hit) |=> ($stable(cap_ns) && $stable(cap_sec))); // R8
  AST_PUSH_IN_FRAME: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    rec_push |-> seen_sfd); // R8
  AST_EMPTY_NO_ACK: assert property (@(posedge host_clk) disable iff (!host_rst_n)
    (rd_req && fifo_empty) |=> !rd_ack); // R9
  AST_ACK_SINGLE: assert property (@(posedge host_clk) disable iff (!host_rst_n)
    rd_ack |=> !rd_ack); // R9
endmodule

// File: tb/ptp_stamp_unit_tb.sv
module ptp_stamp_unit_tb;
  logic rx_clk = 0, host_clk = 0, rx_rst_n = 0, host_rst_n = 0;
  logic gmii_dv = 0, rd_req = 0;
  logic [7:0] gmii_d = 0;
  logic [47:0] rtc_sec = 0;
  logic [31:0] rtc_ns = 0;
  logic fifo_full, overflow, rd_ack, fifo_empty;
  logic [127:0] rd_data;

  always #2.5 rx_clk = ~rx_clk;
  always #3.5 host_clk = ~host_clk;

  ptp_stamp_unit u_dut (
    .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .gmii_dv(gmii_dv), .gmii_d(gmii_d),
    .rtc_sec(rtc_sec), .rtc_ns(rtc_ns), .fifo_full(fifo_full), .overflow(overflow),
    .host_clk(host_clk), .host_rst_n(host_rst_n), .rd_req(rd_req), .rd_ack(rd_ack),
    .rd_data(rd_data), .fifo_empty(fifo_empty));

  typedef struct packed {
    logic [1:0]  encap;   // 0 L2, 1 IPv4, 2 IPv6, 3 raw EtherType
    logic [1:0]  vl;
    logic [1:0]  mp;
    logic [3:0]  ihl;
    logic [15:0] et;
    logic [15:0] port;
    logic [3:0]  msg;
    logic [15:0] seq;
    logic        exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd0, 2'd0, 4'd0, 16'h0000, 16'd0,   4'h0, 16'h1234, 1'b1},
    '{2'd1, 2'd0, 2'd0, 4'd5, 16'h0000, 16'd319, 4'h1, 16'h0002, 1'b1},
    '{2'd1, 2'd0, 2'd0, 4'd6, 16'h0000, 16'd320, 4'h8, 16'hBEEF, 1'b1},
    '{2'd2, 2'd0, 2'd0, 4'd0, 16'h0000, 16'd319, 4'h3, 16'h0444, 1'b1},
    '{2'd1, 2'd0, 2'd0, 4'd5, 16'h0000, 16'd321, 4'h1, 16'h0009, 1'b0},
    '{2'd0, 2'd2, 2'd0, 4'd0, 16'h0000, 16'd0,   4'h2, 16'h5555, 1'b1},
    '{2'd2, 2'd1, 2'd2, 4'd0, 16'h0000, 16'd319, 4'h9, 16'h6666, 1'b1},
    '{2'd1, 2'd0, 2'd1, 4'd5, 16'h0000, 16'd320, 4'hB, 16'h7777, 1'b1},
    '{2'd0, 2'd3, 2'd0, 4'd0, 16'h0000, 16'd0,   4'h2, 16'h0BAD, 1'b0},
    '{2'd3, 2'd0, 2'd0, 4'd0, 16'h0806, 16'd0,   4'h0, 16'h0000, 1'b0}
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R2";  1: return "R3";  2: return "R3";  3: return "R4";
      4: return "R5";  5: return "R6";  6: return "R7";  7: return "R7";
      8: return "R6";  default: return "R12";
    endcase
  endfunction

  int checks = 0, fails = 0, frame_no = 0;
  bit done = 0;
  logic [7:0] fb [512];
  int fl;
  logic [47:0] exp_sec;
  logic [31:0] exp_ns;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic put(input logic [7:0] b);
    fb[fl] = b;
    fl++;
  endtask

  task automatic build(input vec_t v);
    fl = 0;
    for (int i = 0; i < 7; i++) put(8'h55);
    put(8'hD5);
    for (int i = 0; i < 12; i++) put(8'h10 + 8'(i));
    for (int i = 0; i < int'(v.vl); i++) begin put(8'h81); put(8'h00); put(8'h00); put(8'h05); end
    if (v.encap == 2'd3) begin
      put(v.et[15:8]); put(v.et[7:0]);
      for (int i = 0; i < 60; i++) put(8'h00);
      return;
    end
    if (v.mp != 0) begin
      put(8'h88); put(8'h47);
      for (int i = 0; i < int'(v.mp); i++) begin
        put(8'h00); put(8'h01); put((i == int'(v.mp) - 1) ? 8'h01 : 8'h00); put(8'h40);
      end
    end else if (v.encap == 2'd0) begin put(8'h88); put(8'hF7); end
    else if (v.encap == 2'd1) begin put(8'h08); put(8'h00); end
    else begin put(8'h86); put(8'hDD); end
    if (v.encap == 2'd1) begin
      put({4'h4, v.ihl});
      for (int k = 1; k < 4 * int'(v.ihl); k++) put((k == 9) ? 8'd17 : 8'h00);
    end
    if (v.encap == 2'd2) begin
      put(8'h60);
      for (int k = 1; k < 40; k++) put((k == 6) ? 8'd17 : 8'h00);
    end
    if (v.encap != 2'd0) begin
      put(8'h01); put(8'h3F); put(v.port[15:8]); put(v.port[7:0]);
      put(8'h00); put(8'h40); put(8'hAB); put(8'hCD);
    end
    put({4'h0, v.msg}); put(8'h02);
    for (int k = 2; k < 30; k++) put(8'h00);
    put(v.seq[15:8]); put(v.seq[7:0]);
    for (int k = 0; k < 10; k++) put(8'h00);
  endtask

  task automatic send_frame();
    frame_no++;
    for (int i = 0; i < fl; i++) begin
      @(negedge rx_clk);
      gmii_dv = 1; gmii_d = fb[i];
      rtc_sec = 48'h0001_0000_0000 + 48'(frame_no);
      rtc_ns  = 32'(frame_no * 1000 + i);
      if (i == 7) begin exp_sec = rtc_sec; exp_ns = rtc_ns; end
    end
    @(negedge rx_clk);
    gmii_dv = 0; gmii_d = 0;
    repeat (12) @(negedge rx_clk);
    repeat (6) @(negedge host_clk);
  endtask

  task automatic read_rec(output bit got, output logic [127:0] data);
    got = 0; data = '0;
    @(negedge host_clk);
    rd_req = 1;
    for (int k = 0; k < 20 && !got; k++) begin
      @(negedge host_clk);
      if (rd_ack) begin got = 1; data = rd_data; end
    end
    rd_req = 0;
    @(negedge host_clk);
  endtask

  task automatic l2_frame(input logic [15:0] seq);
    vec_t v;
    v = '{2'd0, 2'd0, 2'd0, 4'd0, 16'h0, 16'd0, 4'h0, seq, 1'b1};
    build(v);
  endtask

  initial begin
    repeat (200000) @(posedge rx_clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R11 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit got;
    logic [127:0] d, e;
    logic [11:0] cs;
    repeat (5) @(negedge rx_clk);
    rx_rst_n = 1; host_rst_n = 1;
    repeat (3) @(negedge host_clk);
    @(negedge rx_clk);
    check(fifo_full == 0, "R11 full", 128'(fifo_full), 0);
    check(overflow == 0, "R11 overflow", 128'(overflow), 0);
    @(negedge host_clk);
    check(fifo_empty == 1, "R11 empty", 128'(fifo_empty), 1);
    check(rd_ack == 0 && rd_data == 0, "R11 read port", rd_data, 0);
    read_rec(got, d);
    check(!got, "R9 no ack when empty", 128'(got), 0);

    for (int i = 0; i < NV; i++) begin
      build(VEC[i]);
      send_frame();
      if (VEC[i].exp) begin
        cs = (VEC[i].encap == 2'd0) ? 12'h000 : 12'hBCD;
        e = {16'h0000, exp_sec, exp_ns, VEC[i].msg, cs, VEC[i].seq};
        read_rec(got, d);
        check(got, {"R9 ack ", tag_of(i)}, 128'(got), 1);
        check(d == e, {"R1 R8 record ", tag_of(i)}, d, e);
      end else begin
        check(fifo_empty == 1, {"no record ", tag_of(i)}, 128'(fifo_empty), 1);
      end
    end

    // R8: frame cut off before its sequence number
    l2_frame(16'h4242);
    fl = 8 + 14 + 20;
    send_frame();
    check(fifo_empty == 1, "R8 truncated frame", 128'(fifo_empty), 1);

    // R10: fill, overflow, drain
    for (int n = 0; n < 16; n++) begin
      l2_frame(16'h0100 + 16'(n));
      send_frame();
    end
    @(negedge rx_clk);
    check(fifo_full == 1, "R10 full at 16", 128'(fifo_full), 1);
    check(overflow == 0, "R10 no overflow yet", 128'(overflow), 0);
    l2_frame(16'h01FF);
    send_frame();
    @(negedge rx_clk);
    check(overflow == 1, "R10 overflow set", 128'(overflow), 1);
    for (int n = 0; n < 16; n++) begin
      read_rec(got, d);
      check(got && d[15:0] == 16'h0100 + 16'(n), "R10 drain order", 128'(d[15:0]), 128'(16'h0100 + 16'(n)));
    end
    read_rec(got, d);
    check(!got, "R10 dropped record absent", d, 0);
    check(fifo_empty == 1, "R10 empty after drain", 128'(fifo_empty), 1);
    repeat (4) @(negedge rx_clk);
    check(fifo_full == 0, "R10 full cleared", 128'(fifo_full), 0);
    check(overflow == 1, "R10 overflow sticky", 128'(overflow), 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule